// File: doc/BRIEF.md
# Paired-channel PWM generator

This block is one slice of a pulse-width-modulation peripheral. It holds two output channels that share a single clock configuration: a source selector and a power-of-two divider. Each channel then applies its own prescaler, period length, active-phase length and polarity. Software programs the slice through a simple strobe interface with an address, 32-bit write data and registered read data. Each channel drives an output value and an output-enable. While a channel is disabled, its output-enable is low, so the pad is released to high impedance.

The slice has no clock multiplexer. Two clock-enable inputs, an oscillator tick and a bus tick, stand in for the two possible timebases. The selected tick is divided by 2^div_m to form the pair tick. Each channel divides the pair tick again by its prescale value plus one, and counts a period of E+1 of these channel ticks. A write to a channel's control or period register takes effect on the next clock. The channel drops the period it was in and starts a new period from the beginning.

Register map (byte addresses): 0x00 pair clock configuration, 0x04 clock gate, 0x08 enable, 0x10 + 8*ch channel control, 0x14 + 8*ch channel period.

Top module: `pwm_pair_slice`

## Requirements
- R1: After reset, every register reads as zero and both `pwm_oe` bits and both `pwm_out` bits are 0.
- R2: A read strobe returns on `reg_rdata`, one clock later, the full 32-bit word last written to the addressed register. Addresses: configuration 0x00, gate 0x04, enable 0x08, control 0x10/0x18, period 0x14/0x1C.
- R3: Configuration bits 8:7 select the timebase. The value 0 uses `osc_tick`. Any nonzero value uses `bus_tick`, and the unselected tick then has no effect.
- R4: Configuration bits 3:0 hold an exponent. The selected tick is divided by 2 to the power of this exponent, and any value above 8 acts as 8.
- R5: Control bits 7:0 hold a prescale value K. One channel tick lasts K+1 pair ticks.
- R6: Period bits 31:16 hold E and bits 15:0 hold A. One output period is E+1 channel ticks long. The output is active during the first A ticks of each period and inactive for the rest. When A is greater than E, the output is active all the time. When A is 0, the output is inactive all the time.
- R7: Control bit 8 sets the polarity. With 1, the active level is high. With 0, the active level is low.
- R8: Enable bit ch drives `pwm_oe[ch]` from the next clock. A disabled channel outputs 0 with its output-enable low. An enabled channel starts at the beginning of a period.
- R9: Gate bit ch must be 1 for the channel to count. An enabled channel with its gate bit at 0 (and bypass clear) holds the inactive level.
- R10: When gate bit ch+16 (bypass) is 1 on an enabled channel, the output is a square wave. The wave toggles on every pair tick, so its period is 2*2^exponent selected ticks, and polarity and period settings do not affect it.
- R11: A write to a channel's control or period register restarts that channel at the beginning of a period on the next clock. The period in progress is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | Oscillator timebase clock-enable |
| bus_tick | input | 1 | Bus timebase clock-enable |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the clock after `reg_rd` |
| pwm_out | output | 2 | Channel output values |
| pwm_oe | output | 2 | Channel output-enables (0 releases the pin) |

## Verification
A stale or skewed period counter shows up in the cycle right after a restart. A restarted channel must come out at its active level at once if A is nonzero, so a counter that fails to clear is seen within one clock. A prescaler or divider that wraps at the wrong count does not appear at once. It shows only as a wrong high time or period length, so those are measured over a full steady period, up to a few hundred clocks. Errors in the gate, enable and bypass state appear on `pwm_oe` or on a held output level in the clock after the write.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;

   // register byte addresses
   localparam int ADR_CLKCFG    = 'h00;
   localparam int ADR_GATE      = 'h04;
   localparam int ADR_EN        = 'h08;
   localparam int ADR_CH_BASE   = 'h10;
   localparam int ADR_CH_STRIDE = 8;
   localparam int ADR_PER_OFS   = 4;

   // field positions
   localparam int SRC_LSB   = 7;
   localparam int SRC_W     = 2;
   localparam int DIV_LSB   = 0;
   localparam int POL_BIT   = 8;
   localparam int PRESC_LSB = 0;
   localparam int DUR_E_LSB = 16;
   localparam int DUR_A_LSB = 0;
   localparam int BYP_OFS   = 16;

   function automatic int ctrl_addr(input int ch);
      return ADR_CH_BASE + ch * ADR_CH_STRIDE;
   endfunction

   function automatic int per_addr(input int ch);
      return ADR_CH_BASE + ch * ADR_CH_STRIDE + ADR_PER_OFS;
   endfunction

endpackage

// File: rtl/pwm_pair_regs.sv
module pwm_pair_regs
   import pwm_pair_pkg::*;
#(
   parameter int NUM_CH      = 2,
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 32,
   parameter int DIV_FIELD_W = 4,
   parameter int PRESC_W     = 8,
   parameter int CNT_W       = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr,
   input  logic                   rd,
   input  logic [ADDR_W-1:0]      addr,
   input  logic [DATA_W-1:0]      wdata,
   output logic [DATA_W-1:0]      rdata,
   output logic [SRC_W-1:0]       src_sel,
   output logic [DIV_FIELD_W-1:0] div_exp,
   output logic [NUM_CH-1:0]      gate_on,
   output logic [NUM_CH-1:0]      bypass,
   output logic [NUM_CH-1:0]      en,
   output logic [NUM_CH-1:0]      act_hi,
   output logic [PRESC_W-1:0]     presc [NUM_CH],
   output logic [CNT_W-1:0]       per_e [NUM_CH],
   output logic [CNT_W-1:0]       per_a [NUM_CH],
   output logic [NUM_CH-1:0]      restart
);

   localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(ADR_CLKCFG);
   localparam logic [ADDR_W-1:0] A_GATE = ADDR_W'(ADR_GATE);
   localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(ADR_EN);

   logic [DATA_W-1:0] cfg_q, gate_q, en_q;
   logic [DATA_W-1:0] ctrl_q [NUM_CH];
   logic [DATA_W-1:0] per_q  [NUM_CH];
   logic [DATA_W-1:0] rd_mux;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         gate_q <= '0;
         en_q   <= '0;
      end else if (wr) begin
         if (addr == A_CFG)  cfg_q  <= wdata;
         if (addr == A_GATE) gate_q <= wdata;
         if (addr == A_EN)   en_q   <= wdata;
      end
   end

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ctrl_addr(c));
         localparam logic [ADDR_W-1:0] A_PER  = ADDR_W'(per_addr(c));
         logic hit_ctrl, hit_per;

         assign hit_ctrl = wr && (addr == A_CTRL);
         assign hit_per  = wr && (addr == A_PER);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ctrl_q[c] <= '0;
               per_q[c]  <= '0;
            end else begin
               if (hit_ctrl) ctrl_q[c] <= wdata;
               if (hit_per)  per_q[c]  <= wdata;
            end
         end

         assign restart[c] = hit_ctrl || hit_per;
         assign gate_on[c] = gate_q[c];
         assign bypass[c]  = gate_q[BYP_OFS + c];
         assign en[c]      = en_q[c];
         assign act_hi[c]  = ctrl_q[c][POL_BIT];
         assign presc[c]   = ctrl_q[c][PRESC_LSB +: PRESC_W];
         assign per_e[c]   = per_q[c][DUR_E_LSB +: CNT_W];
         assign per_a[c]   = per_q[c][DUR_A_LSB +: CNT_W];
      end
   endgenerate

   assign src_sel = cfg_q[SRC_LSB +: SRC_W];
   assign div_exp = cfg_q[DIV_LSB +: DIV_FIELD_W];

   always_comb begin
      rd_mux = '0;
      if (addr == A_CFG)  rd_mux = cfg_q;
      if (addr == A_GATE) rd_mux = gate_q;
      if (addr == A_EN)   rd_mux = en_q;
      for (int c = 0; c < NUM_CH; c++) begin
         if (addr == ADDR_W'(ctrl_addr(c))) rd_mux = ctrl_q[c];
         if (addr == ADDR_W'(per_addr(c)))  rd_mux = per_q[c];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  rdata <= '0;
      else if (rd) rdata <= rd_mux;
   end

endmodule

// File: rtl/pwm_pair_clkdiv.sv
module pwm_pair_clkdiv #(
   parameter int SRC_W       = 2,
   parameter int DIV_FIELD_W = 4,
   parameter int DIV_EXP_MAX = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   osc_tick,
   input  logic                   bus_tick,
   input  logic [SRC_W-1:0]       src_sel,
   input  logic [DIV_FIELD_W-1:0] div_exp,
   output logic                   pair_tick,
   output logic                   pair_clk
);

   logic src_tick;

   assign src_tick = (src_sel != '0) ? bus_tick : osc_tick;

   generate
      if (DIV_EXP_MAX == 0) begin : g_nodiv
         assign pair_tick = src_tick;
      end else begin : g_div
         localparam int DCNT_W = DIV_EXP_MAX;
         localparam logic [DIV_FIELD_W-1:0] EXP_CAP = DIV_FIELD_W'(DIV_EXP_MAX);

         logic [DIV_FIELD_W-1:0] exp_eff;
         logic [DCNT_W-1:0]      lim;
         logic [DCNT_W-1:0]      dcnt;
         logic                   wrap;

         assign exp_eff = (div_exp > EXP_CAP) ? EXP_CAP : div_exp;
         // lowest exp_eff bits set: 2^exp - 1
         assign lim  = ~({DCNT_W{1'b1}} << exp_eff);
         assign wrap = (dcnt >= lim);

         always_ff @(posedge clk) begin
            if (!rst_n)        dcnt <= '0;
            else if (src_tick) dcnt <= wrap ? '0 : dcnt + 1'b1;
         end

         assign pair_tick = src_tick && wrap;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)         pair_clk <= 1'b0;
      else if (pair_tick) pair_clk <= ~pair_clk;
   end

endmodule

// File: rtl/pwm_pair_chan.sv
module pwm_pair_chan #(
   parameter int PRESC_W = 8,
   parameter int CNT_W   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pair_tick,
   input  logic               pair_clk,
   input  logic               en,
   input  logic               gate_on,
   input  logic               bypass,
   input  logic               act_hi,
   input  logic [PRESC_W-1:0] presc,
   input  logic [CNT_W-1:0]   per_e,
   input  logic [CNT_W-1:0]   per_a,
   input  logic               restart,
   output logic               out,
   output logic               oe
);

   logic               run;
   logic [PRESC_W-1:0] pre_cnt;
   logic               pre_wrap;
   logic               ch_tick;
   logic [CNT_W-1:0]   cnt;
   logic               active;
   logic               level;

   assign run      = en && gate_on;
   assign pre_wrap = (pre_cnt >= presc);
   assign ch_tick  = run && pair_tick && pre_wrap;

   always_ff @(posedge clk) begin
      if (!rst_n || !run || restart) pre_cnt <= '0;
      else if (pair_tick)            pre_cnt <= pre_wrap ? '0 : pre_cnt + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !run || restart) cnt <= '0;
      else if (ch_tick)              cnt <= (cnt >= per_e) ? '0 : cnt + 1'b1;
   end

   assign active = run && (cnt < per_a);
   assign level  = act_hi ? active : !active;

   always_comb begin
      if (!en)         out = 1'b0;
      else if (bypass) out = pair_clk;
      else             out = level;
   end

   assign oe = en;

endmodule

// File: rtl/pwm_pair_slice.sv
module pwm_pair_slice
   import pwm_pair_pkg::*;
#(
   parameter int NUM_CH      = 2,
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 32,
   parameter int DIV_FIELD_W = 4,
   parameter int DIV_EXP_MAX = 8,
   parameter int PRESC_W     = 8,
   parameter int CNT_W       = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              osc_tick,
   input  logic              bus_tick,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [NUM_CH-1:0] pwm_out,
   output logic [NUM_CH-1:0] pwm_oe
);

   generate
      if (NUM_CH != 2) begin : g_bad_ch
         $error("pwm_pair_slice: NUM_CH must be 2");
      end
      if (DUR_E_LSB + CNT_W > DATA_W || DUR_A_LSB + CNT_W > DUR_E_LSB) begin : g_bad_cnt
         $error("pwm_pair_slice: CNT_W does not fit the period word");
      end
      if (PRESC_W > POL_BIT) begin : g_bad_presc
         $error("pwm_pair_slice: PRESC_W overlaps the polarity bit");
      end
      if (DIV_EXP_MAX >= (1 << DIV_FIELD_W)) begin : g_bad_div
         $error("pwm_pair_slice: DIV_EXP_MAX not encodable in DIV_FIELD_W");
      end
      if (BYP_OFS + NUM_CH > DATA_W || ADR_CH_BASE + NUM_CH * ADR_CH_STRIDE > (1 << ADDR_W)) begin : g_bad_map
         $error("pwm_pair_slice: register map does not fit");
      end
   endgenerate

   logic [SRC_W-1:0]       src_sel;
   logic [DIV_FIELD_W-1:0] div_exp;
   logic [NUM_CH-1:0]      gate_on, bypass, en, act_hi, restart;
   logic [PRESC_W-1:0]     presc [NUM_CH];
   logic [CNT_W-1:0]       per_e [NUM_CH];
   logic [CNT_W-1:0]       per_a [NUM_CH];
   logic                   pair_tick, pair_clk;

   pwm_pair_regs #(
      .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .DIV_FIELD_W(DIV_FIELD_W), .PRESC_W(PRESC_W), .CNT_W(CNT_W)
   ) regs_i (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd),
      .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
      .src_sel(src_sel), .div_exp(div_exp),
      .gate_on(gate_on), .bypass(bypass), .en(en), .act_hi(act_hi),
      .presc(presc), .per_e(per_e), .per_a(per_a), .restart(restart)
   );

   pwm_pair_clkdiv #(
      .SRC_W(SRC_W), .DIV_FIELD_W(DIV_FIELD_W), .DIV_EXP_MAX(DIV_EXP_MAX)
   ) div_i (
      .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .bus_tick(bus_tick),
      .src_sel(src_sel), .div_exp(div_exp),
      .pair_tick(pair_tick), .pair_clk(pair_clk)
   );

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
         pwm_pair_chan #(.PRESC_W(PRESC_W), .CNT_W(CNT_W)) chan_i (
            .clk(clk), .rst_n(rst_n),
            .pair_tick(pair_tick), .pair_clk(pair_clk),
            .en(en[c]), .gate_on(gate_on[c]), .bypass(bypass[c]),
            .act_hi(act_hi[c]), .presc(presc[c]),
            .per_e(per_e[c]), .per_a(per_a[c]), .restart(restart[c]),
            .out(pwm_out[c]), .oe(pwm_oe[c])
         );
      end
   endgenerate

endmodule

// File: rtl/pwm_pair_slice_chk.sv
module pwm_pair_slice_chk
   import pwm_pair_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic [NUM_CH-1:0] pwm_out,
   input logic [NUM_CH-1:0] pwm_oe
);

   localparam logic [ADDR_W-1:0] A_GATE = ADDR_W'(ADR_GATE);
   localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(ADR_EN);

   // shadow of the programmed state, rebuilt from the write bus
   logic [DATA_W-1:0] sh_en_word;
   logic [NUM_CH-1:0] sh_gate, sh_byp, sh_pol;
   logic [CNT_W-1:0]  sh_a [NUM_CH];
   logic [CNT_W-1:0]  sh_e [NUM_CH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_en_word <= '0;
         sh_gate    <= '0;
         sh_byp     <= '0;
      end else if (reg_wr) begin
         if (reg_addr == A_EN) sh_en_word <= reg_wdata;
         if (reg_addr == A_GATE) begin
            sh_gate <= reg_wdata[NUM_CH-1:0];
            sh_byp  <= reg_wdata[BYP_OFS +: NUM_CH];
         end
      end
   end

   // R2: enable register read returns the value in force before the read edge
   assert_readback_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd && reg_addr == A_EN |=> reg_rdata == $past(sh_en_word));

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ctrl_addr(c));
         localparam logic [ADDR_W-1:0] A_PER  = ADDR_W'(per_addr(c));
         logic running;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sh_pol[c] <= 1'b0;
               sh_a[c]   <= '0;
               sh_e[c]   <= '0;
            end else if (reg_wr) begin
               if (reg_addr == A_CTRL) sh_pol[c] <= reg_wdata[POL_BIT];
               if (reg_addr == A_PER) begin
                  sh_a[c] <= reg_wdata[DUR_A_LSB +: CNT_W];
                  sh_e[c] <= reg_wdata[DUR_E_LSB +: CNT_W];
               end
            end
         end

         assign running = sh_en_word[c] && sh_gate[c] && !sh_byp[c];

         assert_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !pwm_oe[c] |-> !pwm_out[c]);

         assert_oe_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
            reg_wr && reg_addr == A_EN |=> pwm_oe[c] == $past(reg_wdata[c]));

         assert_zero_duty_R6: assert property (@(posedge clk) disable iff (!rst_n)
            running && sh_a[c] == '0 |-> pwm_out[c] == !sh_pol[c]);

         assert_full_duty_R6: assert property (@(posedge clk) disable iff (!rst_n)
            running && sh_a[c] > sh_e[c] |-> pwm_out[c] == sh_pol[c]);

         assert_gate_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
            sh_en_word[c] && !sh_gate[c] && !sh_byp[c] |-> pwm_out[c] == !sh_pol[c]);

         assert_restart_active_R11: assert property (@(posedge clk) disable iff (!rst_n)
            reg_wr && (reg_addr == A_PER || reg_addr == A_CTRL)
            |=> !(running && sh_a[c] != '0) || pwm_out[c] == sh_pol[c]);
      end
   endgenerate

endmodule

bind pwm_pair_slice pwm_pair_slice_chk #(
   .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) chk_i (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
   .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
   .pwm_out(pwm_out), .pwm_oe(pwm_oe)
);

// File: tb/pwm_pair_slice_tb_top.sv
`timescale 1ns/1ps
module pwm_pair_slice_tb_top;

   localparam logic [7:0] A_CFG   = 8'h00;
   localparam logic [7:0] A_GATE  = 8'h04;
   localparam logic [7:0] A_EN    = 8'h08;
   localparam logic [7:0] A_CTRL0 = 8'h10;
   localparam logic [7:0] A_PER0  = 8'h14;
   localparam logic [7:0] A_CTRL1 = 8'h18;
   localparam logic [7:0] A_PER1  = 8'h1C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        osc_tick = 1'b1;
   logic        bus_tick = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [1:0]  pwm_out, pwm_oe;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   typedef struct {
      int    ch;
      logic  out;
      logic  oe;
      string tag;
   } sb_item_t;

   sb_item_t sb_q[$];

   always #2 clk = ~clk;

   pwm_pair_slice dut_i (
      .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .bus_tick(bus_tick),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .pwm_out(pwm_out), .pwm_oe(pwm_oe)
   );

   task automatic check(input bit ok, input string tag,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // bus timebase: one tick in three clocks
   initial begin
      int ph = 0;
      forever begin
         @(negedge clk);
         bus_tick = (ph == 2);
         ph = (ph + 1) % 3;
      end
   end

   // scoreboard monitor
   always @(negedge clk) begin
      if (sb_q.size() != 0) begin
         sb_item_t it;
         it = sb_q.pop_front();
         check(pwm_out[it.ch] === it.out && pwm_oe[it.ch] === it.oe, it.tag,
               {30'd0, pwm_oe[it.ch], pwm_out[it.ch]}, {30'd0, it.oe, it.out});
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      #1 reg_wr = 1'b0;
   endtask

   task automatic rd_check(input logic [7:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      @(posedge clk);
      #1 reg_rd = 1'b0;
      @(negedge clk);
      check(reg_rdata === exp, tag, reg_rdata, exp);
   endtask

   // expected waveform from position 0 (start of a period) onward
   task automatic push_pattern(input int ch, input int e, input int a, input bit act_hi,
                               input int n, input string tag);
      for (int j = 0; j < n; j++) begin
         sb_item_t it;
         bit act;
         act = ((j % (e + 1)) < a);
         it.ch = ch; it.out = act_hi ? act : !act; it.oe = 1'b1; it.tag = tag;
         sb_q.push_back(it);
      end
   endtask

   task automatic push_const(input int ch, input bit o, input bit oe, input int n,
                             input string tag);
      for (int j = 0; j < n; j++) begin
         sb_item_t it;
         it.ch = ch; it.out = o; it.oe = oe; it.tag = tag;
         sb_q.push_back(it);
      end
   endtask

   task automatic drain();
      while (sb_q.size() != 0) @(posedge clk);
   endtask

   task automatic measure(input int ch, output int hi, output int per);
      logic prev;
      int lo;
      @(negedge clk);
      prev = pwm_out[ch];
      forever begin
         @(negedge clk);
         if (!prev && pwm_out[ch]) break;
         prev = pwm_out[ch];
      end
      hi = 0;
      while (pwm_out[ch] === 1'b1) begin hi++; @(negedge clk); end
      lo = 0;
      while (pwm_out[ch] === 1'b0) begin lo++; @(negedge clk); end
      per = hi + lo;
   endtask

   initial begin
      int hi, per;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check(pwm_oe === 2'b00, "R1 oe after reset", pwm_oe, 0);
      check(pwm_out === 2'b00, "R1 out after reset", pwm_out, 0);
      rd_check(A_CFG, 0, "R1 cfg reset");
      rd_check(A_GATE, 0, "R1 gate reset");
      rd_check(A_EN, 0, "R1 en reset");
      rd_check(A_CTRL0, 0, "R1 ctrl0 reset");
      rd_check(A_PER1, 0, "R1 per1 reset");

      // R6: basic waveform, ch0 E=4 A=2 active high
      wr(A_CFG, 32'h0);
      wr(A_GATE, 32'h3);
      wr(A_CTRL0, 32'h100);
      wr(A_PER0, 32'h0004_0002);
      wr(A_EN, 32'h1);
      push_pattern(0, 4, 2, 1'b1, 15, "R6 E4 A2");
      drain();

      // R7: ch1 active low, E=3 A=1
      wr(A_CTRL1, 32'h000);
      wr(A_PER1, 32'h0003_0001);
      wr(A_EN, 32'h3);
      push_pattern(1, 3, 1, 1'b0, 12, "R7 active-low");
      drain();

      // R6: A greater than E, then A zero
      wr(A_PER0, 32'h0002_0005);
      push_pattern(0, 2, 5, 1'b1, 9, "R6 A>E full");
      drain();
      wr(A_PER0, 32'h0002_0000);
      push_pattern(0, 2, 0, 1'b1, 9, "R6 A=0 empty");
      drain();

      // R11: period write mid-period restarts at once
      wr(A_PER0, 32'h0009_0005);
      repeat (3) @(negedge clk);
      wr(A_PER0, 32'h0003_0001);
      push_pattern(0, 3, 1, 1'b1, 12, "R11 period restart");
      drain();
      repeat (2) @(negedge clk);
      wr(A_CTRL0, 32'h100);
      push_pattern(0, 3, 1, 1'b1, 8, "R11 control restart");
      drain();

      // R9: gate cleared holds inactive level
      wr(A_GATE, 32'h2);
      push_pattern(0, 0, 0, 1'b1, 6, "R9 gate off high-pol");
      drain();
      wr(A_CTRL0, 32'h000);
      push_pattern(0, 0, 0, 1'b0, 6, "R9 gate off low-pol");
      drain();
      wr(A_GATE, 32'h3);
      wr(A_CTRL0, 32'h100);

      // R8: disable releases pin
      wr(A_EN, 32'h2);
      push_const(0, 1'b0, 1'b0, 4, "R8 disabled");
      drain();

      // R4 and R5: cascaded dividers, exp=2, K=2, E=3, A=1
      wr(A_EN, 32'h0);
      wr(A_CFG, 32'h002);
      wr(A_CTRL0, 32'h102);
      wr(A_PER0, 32'h0003_0001);
      wr(A_EN, 32'h1);
      measure(0, hi, per);
      check(hi == 12, "R5 high time", hi, 12);
      check(per == 48, "R4 period", per, 48);

      // R3: bus timebase, one tick in three
      wr(A_EN, 32'h0);
      wr(A_CFG, 32'h080);
      wr(A_CTRL0, 32'h100);
      wr(A_PER0, 32'h0001_0001);
      wr(A_EN, 32'h1);
      measure(0, hi, per);
      check(hi == 3, "R3 bus high", hi, 3);
      check(per == 6, "R3 bus period", per, 6);
      wr(A_CFG, 32'h100);
      measure(0, hi, per);
      check(per == 6, "R3 src=2 bus period", per, 6);
      wr(A_CFG, 32'h000);
      measure(0, hi, per);
      check(per == 2, "R3 osc period", per, 2);

      // R10: bypass square wave; R4 exponent clamp
      wr(A_EN, 32'h0);
      wr(A_CFG, 32'h001);
      wr(A_GATE, 32'h0001_0003);
      wr(A_EN, 32'h1);
      measure(0, hi, per);
      check(hi == 2, "R10 bypass high", hi, 2);
      check(per == 4, "R10 bypass period", per, 4);
      wr(A_CFG, 32'h008);
      measure(0, hi, per);
      check(per == 512, "R4 exp 8 period", per, 512);
      wr(A_CFG, 32'h00F);
      measure(0, hi, per);
      check(hi == 256, "R4 exp clamp high", hi, 256);
      check(per == 512, "R4 exp clamp period", per, 512);

      // R2: read back of full words
      wr(A_EN, 32'h0);
      wr(A_CTRL1, 32'h0000_01A5);
      wr(A_PER0, 32'hDEAD_BEEF);
      rd_check(A_CTRL1, 32'h0000_01A5, "R2 ctrl1");
      rd_check(A_PER0, 32'hDEAD_BEEF, "R2 per0");
      rd_check(A_GATE, 32'h0001_0003, "R2 gate");
      rd_check(A_CFG, 32'h0000_000F, "R2 cfg");
      rd_check(A_EN, 32'h0, "R2 en");
      rd_check(A_PER1, 32'h0003_0001, "R2 per1");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

endmodule